// File: doc/BRIEF.md
# IPv4 and L4 exception classifier

This block inspects one packet per frame as it streams past, one byte per beat. Each frame begins at the first byte of the IP header. For IPv4 the header is checked in full: it is length-checked, its options are detected, its ones'-complement checksum is verified and its TTL is tested. For a non-fragmented TCP or UDP packet the block then goes on to the transport header that follows. For IPv6 the block recognises the version and checks the fixed header length, the payload length and the hop limit. It does not run transport checks for IPv6.

The cycle after the beat marked last, the block drives a single-cycle status word. The word carries four flags: IPv6, TCP-or-UDP, fragment, and IP exception. It also carries a transport-error flag and an 8-bit code that names the most serious condition found. The priority is not-IP first, then the other IP faults, then fragment, then transport faults. The transport checksum over the pseudo-header is computed elsewhere. Its expected value arrives on a port together with the last byte. The block only compares that value with the checksum field.

Top module: `ipv4_l4_screen`

## Requirements
- R1: The status outputs pulse `st_valid` for exactly the one cycle after each beat with `in_valid` and `in_last` both high, including for back-to-back frames. In every other cycle all status outputs are 0.
- R2: If the high nibble of byte 0 is neither 4 nor 6, the status reports `st_ip_exc`=1 and code 1. The IPv6, TCP-or-UDP and fragment flags are then 0.
- R3: For IPv4, the 16-bit ones'-complement sum of the IHL*4 header bytes (big-endian words) must equal 0xFFFF. Otherwise the status reports IP exception code 2.
- R4: Code 3 is reported in these cases. For IPv4: IHL (low nibble of byte 0) is below 5, or the frame has fewer than IHL*4 bytes, or the total length in bytes 2-3 is below IHL*4. For IPv6: the frame has fewer than 40 bytes.
- R5: Code 4 is reported when the frame is shorter than the IPv4 total length, or shorter than 40 plus the IPv6 payload length (bytes 4-5). Bytes beyond those lengths are accepted without error.
- R6: Code 5 is reported when the IPv4 TTL (byte 8) or the IPv6 hop limit (byte 7) is 0. Code 6 is reported when IHL is above 5.
- R7: IP exception codes are chosen in this order: 1, 3, 2, 4, 5, 6.
- R8: An IPv4 packet is a fragment when bit 5 of byte 6 (more-fragments) is set or the 13-bit offset (byte 6 bits 4:0, byte 7) is nonzero. Without an IP exception, a fragment gives `st_frag`=1 and code 0, and no transport check runs.
- R9: `st_tcp_udp` is set when the protocol byte (byte 9 for IPv4, byte 6 for IPv6) is 6 (TCP) or 17 (UDP). `st_is_v6` follows version 6. Transport checks run only for IPv4.
- R10: Transport code 1 is reported when the IP payload (total length minus IHL*4) is shorter than 8 bytes for UDP or 20 bytes for TCP.
- R11: Transport code 2 is reported when `in_sum_en` is high on the last beat and the checksum field differs from `in_sum_ref`. The field is at transport bytes 6-7 for UDP and 16-17 for TCP. A UDP field of 0 is exempt.
- R12: Transport code 3 is reported when the UDP length (transport bytes 4-5) exceeds the IP payload. Code 4 is reported when the source port (bytes 0-1) or the destination port (bytes 2-3) is 0.
- R13: The TCP flags are the low six bits of transport byte 13 (bit 0 FIN, 1 SYN, 2 RST, 5 URG). They give these codes: 8 for FIN alone, 9 for none set, 10 for FIN with RST, 11 for SYN with URG, 12 for SYN with RST, and 13 for SYN with FIN.
- R14: When several transport conditions hold, the lowest code is reported and `st_l4_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present this cycle |
| in_last | input | 1 | Byte is the frame's last |
| in_data | input | 8 | Frame byte |
| in_sum_en | input | 1 | Transport checksum comparison enable, sampled on last beat |
| in_sum_ref | input | 16 | Expected transport checksum, sampled on last beat |
| st_valid | output | 1 | Status pulse |
| st_is_v6 | output | 1 | Packet is IPv6 |
| st_tcp_udp | output | 1 | Protocol is TCP or UDP |
| st_frag | output | 1 | IPv4 fragment |
| st_ip_exc | output | 1 | IP-level exception |
| st_l4_err | output | 1 | Transport-level error |
| st_code | output | 8 | Error code of highest-priority condition |

## Verification
The block holds its state for a frame in three places: a byte counter, the captured header and transport bytes, and a running checksum. A fault in any of them stays hidden until the status pulse that follows the last byte. There it appears as a wrong code or flag for that frame only, because every capture is cleared on the next first byte. A counter that fails to rewind on the last beat spoils the next frame's field positions. That shows up one frame later, so the frames are sent back to back as well as with gaps. The bench checks every cycle, so a pulse that is late, doubled or missing is seen in the cycle it goes wrong.

// File: rtl/ipv4_l4_screen.sv
`timescale 1ns/1ps
module ipv4_l4_screen #(
  parameter int LEN_W = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  input  logic        in_sum_en,
  input  logic [15:0] in_sum_ref,
  output logic        st_valid,
  output logic        st_is_v6,
  output logic        st_tcp_udp,
  output logic        st_frag,
  output logic        st_ip_exc,
  output logic        st_l4_err,
  output logic [7:0]  st_code
);
  localparam int HDR_KEEP = 10;
  localparam int L4_KEEP  = 20;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] V6_HDR  = LEN_W'(40);

  logic [LEN_W-1:0] cnt, flen, hl, rel, tl_w, need6;
  logic [7:0]  hdr [HDR_KEEP];
  logic [7:0]  l4b [L4_KEEP];
  logic [7:0]  prevb;
  logic [15:0] csum, sum_ref_q;
  logic [16:0] csum_raw;
  logic        sum_en_q, done;

  assign hl       = LEN_W'({hdr[0][3:0], 2'b00});
  assign rel      = cnt - hl;
  assign csum_raw = {1'b0, csum} + {1'b0, prevb, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      flen      <= '0;
      prevb     <= '0;
      csum      <= '0;
      sum_ref_q <= '0;
      sum_en_q  <= 1'b0;
      done      <= 1'b0;
      for (int k = 0; k < HDR_KEEP; k++) hdr[k] <= '0;
      for (int k = 0; k < L4_KEEP; k++) l4b[k] <= '0;
    end else begin
      done <= in_valid && in_last;
      if (in_valid) begin
        prevb <= in_data;
        if (cnt == '0) begin
          csum <= '0;
          for (int k = 0; k < HDR_KEEP; k++) hdr[k] <= '0;
          for (int k = 0; k < L4_KEEP; k++) l4b[k] <= '0;
        end
        if (cnt < LEN_W'(HDR_KEEP))
          hdr[cnt[3:0]] <= in_data;
        if (cnt != '0 && cnt >= hl && rel < LEN_W'(L4_KEEP))
          l4b[rel[4:0]] <= in_data;
        if (cnt[0] && cnt < hl)
          csum <= csum_raw[15:0] + {15'd0, csum_raw[16]};
        if (in_last) begin
          cnt       <= '0;
          flen      <= (cnt == LEN_MAX) ? cnt : cnt + LEN_W'(1);
          sum_en_q  <= in_sum_en;
          sum_ref_q <= in_sum_ref;
        end else if (cnt != LEN_MAX) begin
          cnt <= cnt + LEN_W'(1);
        end
      end
    end
  end

  logic [3:0]  ver, ihl;
  logic        is4, is6, not_ip, frag4, tcp, udp, ipx, elig;
  logic [15:0] tl, pl, pay, sport, dport, ulen, ckf;
  logic [7:0]  proto, ipc, l4c;
  logic [5:0]  tfl;

  assign ver    = hdr[0][7:4];
  assign ihl    = hdr[0][3:0];
  assign is4    = ver == 4'd4;
  assign is6    = ver == 4'd6;
  assign not_ip = !is4 && !is6;
  assign tl     = {hdr[2], hdr[3]};
  assign pl     = {hdr[4], hdr[5]};
  assign tl_w   = LEN_W'(tl);
  assign need6  = LEN_W'(pl) + V6_HDR;
  assign frag4  = hdr[6][5] || ({hdr[6][4:0], hdr[7]} != 13'd0);
  assign proto  = is4 ? hdr[9] : hdr[6];
  assign tcp    = proto == 8'd6;
  assign udp    = proto == 8'd17;

  always_comb begin
    ipc = 8'd0;
    if (not_ip)                                    ipc = 8'd1;
    else if (is4) begin
      if (ihl < 4'd5 || flen < hl || tl_w < hl)    ipc = 8'd3;
      else if (csum != 16'hFFFF)                   ipc = 8'd2;
      else if (flen < tl_w)                        ipc = 8'd4;
      else if (hdr[8] == 8'd0)                     ipc = 8'd5;
      else if (ihl > 4'd5)                         ipc = 8'd6;
    end else begin
      if (flen < V6_HDR)                           ipc = 8'd3;
      else if (flen < need6)                       ipc = 8'd4;
      else if (hdr[7] == 8'd0)                     ipc = 8'd5;
    end
  end

  assign ipx   = ipc != 8'd0;
  assign elig  = is4 && !ipx && !frag4 && (tcp || udp);
  assign pay   = tl - {10'd0, ihl, 2'b00};
  assign sport = {l4b[0], l4b[1]};
  assign dport = {l4b[2], l4b[3]};
  assign ulen  = {l4b[4], l4b[5]};
  assign ckf   = tcp ? {l4b[16], l4b[17]} : {l4b[6], l4b[7]};
  assign tfl   = l4b[13][5:0];

  always_comb begin
    l4c = 8'd0;
    if (elig) begin
      if (pay < (tcp ? 16'd20 : 16'd8))                    l4c = 8'd1;
      else if (sum_en_q && (tcp || ckf != 16'd0) && ckf != sum_ref_q)
                                                           l4c = 8'd2;
      else if (udp && ulen > pay)                          l4c = 8'd3;
      else if (sport == 16'd0 || dport == 16'd0)           l4c = 8'd4;
      else if (tcp) begin
        if (tfl == 6'b000001)                              l4c = 8'd8;
        else if (tfl == 6'b000000)                         l4c = 8'd9;
        else if (tfl[0] && tfl[2])                         l4c = 8'd10;
        else if (tfl[1] && tfl[5])                         l4c = 8'd11;
        else if (tfl[1] && tfl[2])                         l4c = 8'd12;
        else if (tfl[1] && tfl[0])                         l4c = 8'd13;
      end
    end
  end

  assign st_valid   = done;
  assign st_is_v6   = done && is6;
  assign st_tcp_udp = done && !not_ip && (tcp || udp);
  assign st_frag    = done && is4 && frag4 && !ipx;
  assign st_ip_exc  = done && ipx;
  assign st_l4_err  = done && (l4c != 8'd0);
  assign st_code    = !done ? 8'd0 : (ipx ? ipc : l4c);
endmodule

// File: rtl/ipv4_l4_screen_chk.sv
`timescale 1ns/1ps
module ipv4_l4_screen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_last,
  input logic       st_valid,
  input logic       st_is_v6,
  input logic       st_tcp_udp,
  input logic       st_frag,
  input logic       st_ip_exc,
  input logic       st_l4_err,
  input logic [7:0] st_code
);
  // R1
  pulse_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> st_valid);
  // R1
  no_stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(in_valid && in_last));
  // R1
  quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (st_code == 8'd0 && !st_ip_exc && !st_l4_err && !st_frag && !st_is_v6 && !st_tcp_udp));
  // R7
  ip_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_ip_exc |-> (st_code >= 8'd1 && st_code <= 8'd6 && !st_l4_err && !st_frag));
  // R8
  frag_blocks_l4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_frag |-> (!st_l4_err && st_code == 8'd0));
  // R14
  l4_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_l4_err |-> ((st_code >= 8'd1 && st_code <= 8'd4) || (st_code >= 8'd8 && st_code <= 8'd13)));
  // R9
  v6_no_l4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_l4_err |-> (!st_is_v6 && st_tcp_udp));
endmodule

bind ipv4_l4_screen ipv4_l4_screen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .st_valid(st_valid), .st_is_v6(st_is_v6), .st_tcp_udp(st_tcp_udp),
  .st_frag(st_frag), .st_ip_exc(st_ip_exc), .st_l4_err(st_l4_err), .st_code(st_code)
);

// File: tb/ipv4_l4_screen_tb.sv
`timescale 1ns/1ps
module ipv4_l4_screen_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, in_sum_en = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] in_sum_ref = '0;
  logic        st_valid, st_is_v6, st_tcp_udp, st_frag, st_ip_exc, st_l4_err;
  logic [7:0]  st_code;

  always #2 clk = ~clk;

  ipv4_l4_screen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .in_data(in_data),
    .in_sum_en(in_sum_en), .in_sum_ref(in_sum_ref), .st_valid(st_valid), .st_is_v6(st_is_v6),
    .st_tcp_udp(st_tcp_udp), .st_frag(st_frag), .st_ip_exc(st_ip_exc), .st_l4_err(st_l4_err),
    .st_code(st_code)
  );

  logic [7:0]  fr[$];
  logic [26:0] beat_q[$];
  logic [12:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0, fails = 0;
  bit          due = 0, run = 0;
  logic [26:0] b;
  logic [13:0] got, want;
  string       t;

  function automatic int gb(int i);
    return (i < fr.size()) ? int'(fr[i]) : 0;
  endfunction
  function automatic int g16(int i);
    return gb(i) * 256 + gb(i + 1);
  endfunction

  function automatic logic [12:0] model(bit en, int rf);
    int n = fr.size(), ver = gb(0) / 16, ihl = gb(0) % 16;
    int hl = ihl * 4, tl = g16(2), ipc = 0, l4c = 0, s = 0, pay, ck, f;
    bit is4 = (ver == 4), is6 = (ver == 6), frag = 0;
    int proto = is4 ? gb(9) : gb(6);
    bit tcp = (proto == 6), udp = (proto == 17);
    if (!is4 && !is6) ipc = 1;
    else if (is4) begin
      for (int i = 0; i < hl; i += 2) begin
        s += g16(i);
        if (s > 65535) s -= 65535;
      end
      frag = ((gb(6) & 32) != 0) || (((gb(6) % 32) * 256 + gb(7)) != 0);
      if (ihl < 5 || n < hl || tl < hl) ipc = 3;
      else if (s != 65535) ipc = 2;
      else if (n < tl) ipc = 4;
      else if (gb(8) == 0) ipc = 5;
      else if (ihl > 5) ipc = 6;
    end else begin
      if (n < 40) ipc = 3;
      else if (n < 40 + g16(4)) ipc = 4;
      else if (gb(7) == 0) ipc = 5;
    end
    if (is4 && ipc == 0 && !frag && (tcp || udp)) begin
      pay = tl - hl;
      ck  = tcp ? g16(hl + 16) : g16(hl + 6);
      f   = gb(hl + 13) % 64;
      if (pay < (tcp ? 20 : 8)) l4c = 1;
      else if (en && (tcp || ck != 0) && ck != rf) l4c = 2;
      else if (udp && g16(hl + 4) > pay) l4c = 3;
      else if (g16(hl) == 0 || g16(hl + 2) == 0) l4c = 4;
      else if (tcp) begin
        if (f == 1) l4c = 8;
        else if (f == 0) l4c = 9;
        else if ((f & 5) == 5) l4c = 10;
        else if ((f & 34) == 34) l4c = 11;
        else if ((f & 6) == 6) l4c = 12;
        else if ((f & 3) == 3) l4c = 13;
      end
    end
    return {is6, (is4 || is6) && (tcp || udp), is4 && frag && ipc == 0,
            ipc != 0, l4c != 0, 8'(ipc != 0 ? ipc : l4c)};
  endfunction

  task automatic put16(int i, int v);
    fr[i]     = v[15:8];
    fr[i + 1] = v[7:0];
  endtask

  task automatic fix_csum();
    int hl = (int'(fr[0]) % 16) * 4, s = 0;
    put16(10, 0);
    for (int i = 0; i < hl; i += 2) begin
      s += g16(i);
      if (s > 65535) s -= 65535;
    end
    put16(10, (~s) & 65535);
  endtask

  task automatic build_v4(int ihl, int pay, int fw, int ttl, int proto);
    int hl = ihl * 4;
    fr.delete();
    for (int i = 0; i < hl + pay; i++) fr.push_back(8'h00);
    fr[0] = 8'(64 + ihl);
    put16(2, hl + pay);
    put16(4, 16'h1234);
    put16(6, fw);
    fr[8] = 8'(ttl);
    fr[9] = 8'(proto);
    put16(12, 16'h0A00); put16(14, 16'h0001);
    put16(16, 16'h0A00); put16(18, 16'h0002);
    for (int i = 20; i < hl; i++) fr[i] = 8'h01;
    fix_csum();
  endtask

  task automatic set_udp(int sp, int dp, int len, int ck);
    int hl = (int'(fr[0]) % 16) * 4;
    put16(hl, sp); put16(hl + 2, dp); put16(hl + 4, len); put16(hl + 6, ck);
  endtask

  task automatic set_tcp(int sp, int dp, int flags, int ck);
    int hl = (int'(fr[0]) % 16) * 4;
    put16(hl, sp); put16(hl + 2, dp);
    fr[hl + 12] = 8'h50;
    fr[hl + 13] = 8'(flags);
    put16(hl + 16, ck);
  endtask

  task automatic build_v6(int pl, int nh, int hop);
    fr.delete();
    for (int i = 0; i < 40 + pl; i++) fr.push_back(8'h00);
    fr[0] = 8'h60;
    put16(4, pl);
    fr[6] = 8'(nh);
    fr[7] = 8'(hop);
  endtask

  task automatic trunc(int k);
    while (fr.size() > k) void'(fr.pop_back());
  endtask

  task automatic send(string tag, bit en, int rf, int pad, int gap);
    int n;
    for (int i = 0; i < pad; i++) fr.push_back(8'hEE);
    n = fr.size();
    exp_q.push_back(model(en, rf));
    tag_q.push_back(tag);
    for (int i = 0; i < n; i++)
      beat_q.push_back({1'b1, i == n - 1, en, 16'(rf), fr[i]});
    for (int i = 0; i < gap; i++) beat_q.push_back('0);
  endtask

  task automatic good_udp();
    build_v4(5, 16, 0, 64, 17);
    set_udp(1000, 2000, 16, 16'h5555);
  endtask

  task automatic good_tcp(int flags);
    build_v4(5, 24, 16'h4000, 64, 6);
    set_tcp(1111, 80, flags, 16'h7777);
  endtask

  always @(negedge clk) begin
    if (run) begin
      got = {st_valid, st_is_v6, st_tcp_udp, st_frag, st_ip_exc, st_l4_err, st_code};
      if (due) begin
        want = {1'b1, exp_q.pop_front()};
        t    = tag_q.pop_front();
      end else begin
        want = '0;
        t    = "R1 quiet cycle";
      end
      checks++;
      if (got !== want) begin
        fails++;
        $display("FAIL %s: got %b expected %b", t, got, want);
      end
      if (beat_q.size() > 0) begin
        b = beat_q.pop_front();
        in_valid   = b[26];
        in_last    = b[25];
        in_sum_en  = b[24];
        in_sum_ref = b[23:8];
        in_data    = b[7:0];
        due        = b[26] && b[25];
      end else begin
        in_valid = 1'b0; in_last = 1'b0; in_sum_en = 1'b0;
        due      = 1'b0;
      end
    end
  end

  initial begin
    int cyc = 0;
    good_udp();                          send("R9 good udp", 1, 16'h5555, 0, 2);
    good_udp(); fr[0] = 8'h55; fix_csum(); send("R2 version 5", 0, 0, 0, 1);
    good_udp(); fr[0] = 8'h05;           send("R2 version 0", 0, 0, 0, 0);
    good_udp(); fr[11] = fr[11] ^ 8'h01; send("R3 header checksum", 0, 0, 0, 1);
    good_udp(); trunc(12);               send("R4 frame inside header", 0, 0, 0, 1);
    good_udp(); fr[0] = 8'h44; fix_csum(); send("R4 ihl below 5", 0, 0, 0, 1);
    good_udp(); put16(2, 16); fix_csum(); send("R4 total below header", 0, 0, 0, 1);
    good_udp(); trunc(30);               send("R5 frame below total length", 0, 0, 0, 1);
    good_udp();                          send("R5 trailing pad accepted", 1, 16'h5555, 6, 1);
    build_v4(5, 16, 0, 0, 17); set_udp(1000, 2000, 16, 0); send("R6 ttl zero", 0, 0, 0, 1);
    build_v4(7, 16, 0, 64, 17); set_udp(1000, 2000, 16, 0); send("R6 options", 0, 0, 0, 1);
    good_udp(); fr[8] = 0; fr[10] = fr[10] ^ 8'h10; send("R7 checksum over ttl", 0, 0, 0, 1);
    good_udp(); fr[8] = 0; trunc(15);   send("R7 short header over checksum", 0, 0, 0, 1);
    build_v4(6, 16, 0, 0, 17); fr[3] = 8'd100; send("R7 length over ttl", 0, 0, 0, 1);
    build_v4(5, 16, 16'h2000, 64, 17); set_udp(0, 0, 99, 1); send("R8 more fragments", 1, 2, 0, 1);
    build_v4(5, 16, 16'h0005, 64, 6);   send("R8 nonzero offset", 0, 0, 0, 1);
    build_v4(5, 16, 0, 64, 1);          send("R9 other protocol", 0, 0, 0, 1);
    build_v6(20, 6, 9);                 send("R9 ipv6 tcp", 0, 0, 0, 1);
    build_v6(8, 17, 0);                 send("R6 ipv6 hop zero", 0, 0, 0, 1);
    build_v6(8, 17, 5); trunc(30);      send("R4 ipv6 short header", 0, 0, 0, 1);
    build_v6(8, 17, 5); trunc(44);      send("R5 ipv6 short payload", 0, 0, 0, 1);
    build_v4(5, 4, 0, 64, 17);          send("R10 udp too short", 0, 0, 0, 1);
    build_v4(5, 12, 0, 64, 6);          send("R10 tcp too short", 0, 0, 0, 1);
    good_udp();                         send("R11 udp checksum mismatch", 1, 16'h1234, 0, 1);
    good_udp(); set_udp(1000, 2000, 16, 0); send("R11 udp zero field exempt", 1, 16'h1234, 0, 1);
    good_udp();                         send("R11 disabled compare", 0, 16'h1234, 0, 1);
    good_tcp(16'h10);                   send("R11 tcp checksum mismatch", 1, 16'h7778, 0, 1);
    good_udp(); set_udp(1000, 2000, 17, 16'h5555); send("R12 udp length long", 1, 16'h5555, 0, 1);
    good_udp(); set_udp(0, 2000, 16, 16'h5555); send("R12 source port zero", 1, 16'h5555, 0, 1);
    good_tcp(16'h12); put16(22, 0);     send("R12 dest port zero", 1, 16'h7777, 0, 1);
    good_tcp(16'h01);                   send("R13 fin alone", 1, 16'h7777, 0, 0);
    good_tcp(16'h00);                   send("R13 no flags", 1, 16'h7777, 0, 0);
    good_tcp(16'h15);                   send("R13 fin rst", 1, 16'h7777, 0, 0);
    good_tcp(16'h22);                   send("R13 syn urg", 1, 16'h7777, 0, 0);
    good_tcp(16'h06);                   send("R13 syn rst", 1, 16'h7777, 0, 0);
    good_tcp(16'h03);                   send("R13 syn fin", 1, 16'h7777, 0, 0);
    good_tcp(16'hC2);                   send("R13 legal syn", 1, 16'h7777, 0, 0);
    good_tcp(16'h01); put16(20, 0);     send("R14 port beats flags", 1, 16'h7777, 0, 1);
    good_udp(); set_udp(1000, 0, 40, 16'h5555); send("R14 length beats port", 1, 16'h5555, 0, 1);
    good_udp(); set_udp(0, 0, 40, 16'h9);  send("R14 checksum beats rest", 1, 16'h5555, 0, 1);
    for (int i = 0; i < 150; i++) begin
      int k = $urandom_range(0, 6);
      if ($urandom_range(0, 1) == 1) good_tcp($urandom_range(0, 63));
      else good_udp();
      case (k)
        1: fr[$urandom_range(0, 19)] = 8'($urandom_range(0, 255));
        2: begin put16(20 + 2 * $urandom_range(0, 3), 0); end
        3: trunc($urandom_range(1, fr.size()));
        4: begin fr[8] = 8'($urandom_range(0, 1)); fr[6] = 8'($urandom_range(0, 1) * 32); fix_csum(); end
        5: begin fr[20 + $urandom_range(0, 17)] = 8'($urandom_range(0, 255)); end
        default: ;
      endcase
      send("R14 random mix", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1 ? 16'h5555 : 16'h7777,
           $urandom_range(0, 3), $urandom_range(0, 1));
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run   = 1'b1;
    while ((beat_q.size() != 0 || due) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 150000) begin
      fails++;
      $display("FAIL R1 watchdog: got %0d beats left expected 0", beat_q.size());
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule